// File: doc/BRIEF.md
# WFI Sleep and Trap Gate

This block sits at the commit point of a small RISC-V core. It decides the outcome of each retiring instruction that reaches it, with most of the logic devoted to the wait-for-interrupt instruction. A WFI can do one of three things. It can trap, either because its fetch lacked execute permission or because user-mode WFI is forbidden by the timeout-wait control bit. It can retire at once, because an individually enabled interrupt is already pending. Otherwise it puts the pipeline to sleep until such an interrupt appears. The block also raises the environment-call trap for ECALL, and it retires ordinary instructions by stepping the PC by 4.

Trap checks always come before sleeping. A WFI that must fault raises its exception and never enters the halt state, even when no interrupt source could ever wake it. Wake-up looks only at the per-source enables, so the global interrupt-enable bit plays no part. Decode, the physical-memory-protection match, CSR storage and interrupt dispatch all sit outside the block and arrive as plain inputs.

Top module: `wfi_gate`

## Requirements
- R1: The timeout-wait control is bit 21 of `mstatusIn`, and no other bit of that word has any effect. A user-mode WFI with that bit set and execute permission granted raises `trapReq` on the next cycle with `trapCause` = 2 and `trapEpc` equal to the WFI's PC.
- R2: A WFI trapped under R1 never enters the sleep state. `stall` stays low afterwards, even when no interrupt is both pending and enabled.
- R3: Any accepted instruction with `execOk` low, including a WFI, raises `trapCause` = 1 with `trapEpc` equal to its PC. It never sleeps.
- R4: When both the execute fault and the R1 condition apply, cause 1 wins over cause 2.
- R5: In machine mode (`privUser` = 0), WFI ignores the timeout-wait bit and never traps for it.
- R6: A WFI that is allowed to run, issued while `irqPending & irqEnable` is nonzero, does not sleep. It retires on the next cycle with `nextPc` equal to PC + 4. A pending bit whose enable is clear does not count.
- R7: A WFI that is allowed to run, issued while no interrupt is both pending and enabled, raises `stall` from the next cycle onward. `stall` drops combinationally in the first cycle where `irqPending & irqEnable` is nonzero. The cycle after that, `retire` pulses with `nextPc` equal to the WFI's PC + 4.
- R8: ECALL with execute permission traps with cause 8 in user mode and cause 11 in machine mode. `trapEpc` is the ECALL's PC.
- R9: `trapReq` lasts exactly one cycle, and `stall` is low in any cycle where `trapReq` is high.
- R10: `instValid` is ignored in any cycle where the block is asleep, including the wake-up cycle, and in any cycle where `trapReq` is high.
- R11: A synchronous reset (`rst` high at a clock edge) clears the sleep state, `trapReq` and `retire`.
- R12: An ordinary instruction with execute permission (neither WFI nor ECALL) retires on the next cycle with `nextPc` = PC + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | An instruction is presented for commit |
| instIsWfi | input | 1 | The presented instruction is WFI |
| instIsEcall | input | 1 | The presented instruction is ECALL |
| instPc | input | XLEN | PC of the presented instruction |
| privUser | input | 1 | 1 = user mode, 0 = machine mode |
| mstatusIn | input | XLEN | Current status word; bit 21 is the timeout-wait control |
| execOk | input | 1 | Execute-permission check passed for the fetch |
| irqPending | input | NIRQ | Pending interrupt bits |
| irqEnable | input | NIRQ | Per-source interrupt enable bits |
| trapReq | output | 1 | One-cycle trap request |
| trapCause | output | 4 | Exception cause code for the trap |
| trapEpc | output | XLEN | Exception PC (the trapping instruction's PC) |
| retire | output | 1 | One-cycle pulse: instruction completed normally |
| nextPc | output | XLEN | PC to continue at on retire |
| stall | output | 1 | Pipeline held while asleep |

## Verification
Traps and retirements are registered, so they appear one clock edge after the instruction is presented. The one exception is a sleeping WFI, which retires one edge after the wake-up cycle. `stall` rises one edge after the WFI and falls in the same cycle that an enabled interrupt turns pending. The bench queues each expected trap or retirement when it drives the stimulus. A monitor then compares every `trapReq` or `retire` pulse against the head of the queue, 2 ns after the edge. Because any extra pulse counts as a mismatch, stimuli that must be ignored are checked as well. The `stall` checks are made directly, just after the falling edge. For the wake-up case, the check comes 1 ns after the interrupt inputs change.

// File: rtl/wfi_gate_pkg.sv
package wfi_gate_pkg;

  localparam int CAUSE_W = 4;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_FETCH_FAULT = 4'd1,
    CAUSE_ILLEGAL     = 4'd2,
    CAUSE_ECALL_USER  = 4'd8,
    CAUSE_ECALL_MACH  = 4'd11
  } trapCode_e;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic      capture;  // latch the presented PC
    logic      raise;    // launch a trap request next cycle
    trapCode_e code;     // cause to launch with raise
    logic      retire;   // launch a retire pulse next cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/wfi_gate_ctrl.sv
module wfi_gate_ctrl
  import wfi_gate_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         instValid,
  input  logic         instIsWfi,
  input  logic         instIsEcall,
  input  logic         privUser,
  input  logic         twSet,
  input  logic         execOk,
  input  logic         wakeReq,
  input  logic         trapBusy,
  output ctrlStrobes_t strobes,
  output logic         sleeping,
  output logic         stall
);

  logic accept;
  logic goSleep;

  // Nothing new is taken while asleep or while a trap is being launched.
  assign accept = instValid && !sleeping && !trapBusy;

  always_comb begin
    strobes         = '0;
    strobes.code    = CAUSE_FETCH_FAULT;
    goSleep         = 1'b0;
    if (accept) begin
      strobes.capture = 1'b1;
      if (!execOk) begin
        // Permission is checked before decode, so it wins.
        strobes.raise = 1'b1;
        strobes.code  = CAUSE_FETCH_FAULT;
      end else if (instIsEcall) begin
        strobes.raise = 1'b1;
        strobes.code  = privUser ? CAUSE_ECALL_USER : CAUSE_ECALL_MACH;
      end else if (instIsWfi && privUser && twSet) begin
        strobes.raise = 1'b1;
        strobes.code  = CAUSE_ILLEGAL;
      end else if (instIsWfi && !wakeReq) begin
        goSleep = 1'b1;
      end else begin
        strobes.retire = 1'b1;
      end
    end else if (sleeping && wakeReq) begin
      strobes.retire = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sleeping <= 1'b0;
    end else if (goSleep) begin
      sleeping <= 1'b1;
    end else if (sleeping && wakeReq) begin
      sleeping <= 1'b0;
    end
  end

  assign stall = sleeping && !wakeReq;

endmodule

// File: rtl/wfi_gate_dp.sv
module wfi_gate_dp
  import wfi_gate_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [XLEN-1:0]    instPc,
  input  logic [NIRQ-1:0]    irqPending,
  input  logic [NIRQ-1:0]    irqEnable,
  input  ctrlStrobes_t       strobes,
  output logic               wakeReq,
  output logic               trapReq,
  output logic [CAUSE_W-1:0] trapCause,
  output logic [XLEN-1:0]    trapEpc,
  output logic               retire,
  output logic [XLEN-1:0]    nextPc
);

  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  logic [XLEN-1:0] pcHeld;
  logic [XLEN-1:0] retireBase;

  assign wakeReq    = |(irqPending & irqEnable);
  assign retireBase = strobes.capture ? instPc : pcHeld;

  always_ff @(posedge clk) begin
    if (strobes.capture) begin
      pcHeld <= instPc;
    end
    if (strobes.raise) begin
      trapCause <= strobes.code;
      trapEpc   <= instPc;
    end
    if (strobes.retire) begin
      nextPc <= retireBase + PC_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trapReq <= 1'b0;
      retire  <= 1'b0;
    end else begin
      trapReq <= strobes.raise;
      retire  <= strobes.retire;
    end
  end

endmodule

// File: rtl/wfi_gate.sv
module wfi_gate
  import wfi_gate_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NIRQ   = 16,
  parameter int TW_BIT = 21
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instValid,
  input  logic               instIsWfi,
  input  logic               instIsEcall,
  input  logic [XLEN-1:0]    instPc,
  input  logic               privUser,
  input  logic [XLEN-1:0]    mstatusIn,
  input  logic               execOk,
  input  logic [NIRQ-1:0]    irqPending,
  input  logic [NIRQ-1:0]    irqEnable,
  output logic               trapReq,
  output logic [CAUSE_W-1:0] trapCause,
  output logic [XLEN-1:0]    trapEpc,
  output logic               retire,
  output logic [XLEN-1:0]    nextPc,
  output logic               stall
);

  ctrlStrobes_t strobes;
  logic         wakeReq;
  logic         sleeping;
  logic         unusedStatusBits;

  assign unusedStatusBits = ^mstatusIn;

  wfi_gate_ctrl uCtrl (
    .clk         (clk),
    .rst         (rst),
    .instValid   (instValid),
    .instIsWfi   (instIsWfi),
    .instIsEcall (instIsEcall),
    .privUser    (privUser),
    .twSet       (mstatusIn[TW_BIT]),
    .execOk      (execOk),
    .wakeReq     (wakeReq),
    .trapBusy    (trapReq),
    .strobes     (strobes),
    .sleeping    (sleeping),
    .stall       (stall)
  );

  wfi_gate_dp #(.XLEN(XLEN), .NIRQ(NIRQ)) uDp (
    .clk        (clk),
    .rst        (rst),
    .instPc     (instPc),
    .irqPending (irqPending),
    .irqEnable  (irqEnable),
    .strobes    (strobes),
    .wakeReq    (wakeReq),
    .trapReq    (trapReq),
    .trapCause  (trapCause),
    .trapEpc    (trapEpc),
    .retire     (retire),
    .nextPc     (nextPc)
  );

endmodule

// File: rtl/wfi_gate_chk.sv
module wfi_gate_chk #(
  parameter int XLEN   = 32,
  parameter int NIRQ   = 16,
  parameter int TW_BIT = 21
) (
  input logic            clk,
  input logic            rst,
  input logic            instValid,
  input logic            instIsWfi,
  input logic            instIsEcall,
  input logic [XLEN-1:0] instPc,
  input logic            privUser,
  input logic [XLEN-1:0] mstatusIn,
  input logic            execOk,
  input logic [NIRQ-1:0] irqPending,
  input logic [NIRQ-1:0] irqEnable,
  input logic            trapReq,
  input logic [3:0]      trapCause,
  input logic [XLEN-1:0] trapEpc,
  input logic            retire,
  input logic            stall,
  input logic            sleeping
);

  logic taken;
  logic anyWake;

  assign taken   = instValid && !sleeping && !trapReq;
  assign anyWake = (irqPending & irqEnable) != '0;

  p_tw_illegal_r1: assert property (@(posedge clk) disable iff (rst)
    (taken && execOk && !instIsEcall && instIsWfi && privUser && mstatusIn[TW_BIT])
    |=> (trapReq && trapCause == 4'd2 && trapEpc == $past(instPc)));

  p_tw_no_sleep_r2: assert property (@(posedge clk) disable iff (rst)
    (taken && execOk && !instIsEcall && instIsWfi && privUser && mstatusIn[TW_BIT])
    |=> !sleeping);

  p_fetch_fault_r3: assert property (@(posedge clk) disable iff (rst)
    (taken && !execOk) |=> (trapReq && trapCause == 4'd1 && !sleeping));

  p_machine_no_tw_r5: assert property (@(posedge clk) disable iff (rst)
    (taken && execOk && instIsWfi && !instIsEcall && !privUser) |=> !trapReq);

  p_wake_retire_r7: assert property (@(posedge clk) disable iff (rst)
    (sleeping && anyWake) |=> (retire && !sleeping));

  p_one_shot_r9: assert property (@(posedge clk) disable iff (rst)
    trapReq |=> !trapReq);

  p_trap_no_stall_r9: assert property (@(posedge clk) disable iff (rst)
    trapReq |-> !stall);

  p_asleep_ignores_r10: assert property (@(posedge clk) disable iff (rst)
    sleeping |=> !trapReq);

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (!trapReq && !retire && !sleeping));

endmodule

bind wfi_gate wfi_gate_chk #(.XLEN(XLEN), .NIRQ(NIRQ), .TW_BIT(TW_BIT)) uChk (
  .clk         (clk),
  .rst         (rst),
  .instValid   (instValid),
  .instIsWfi   (instIsWfi),
  .instIsEcall (instIsEcall),
  .instPc      (instPc),
  .privUser    (privUser),
  .mstatusIn   (mstatusIn),
  .execOk      (execOk),
  .irqPending  (irqPending),
  .irqEnable   (irqEnable),
  .trapReq     (trapReq),
  .trapCause   (trapCause),
  .trapEpc     (trapEpc),
  .retire      (retire),
  .stall       (stall),
  .sleeping    (sleeping)
);

// File: tb/sim_wfi_gate.sv
`timescale 1ns/1ps
module sim_wfi_gate;

  localparam logic [31:0] TW_ON = 32'h0020_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        instValid, instIsWfi, instIsEcall, privUser, execOk;
  logic [31:0] instPc, mstatusIn;
  logic [15:0] irqPending, irqEnable;
  logic        trapReq, retire, stall;
  logic [3:0]  trapCause;
  logic [31:0] trapEpc, nextPc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit          qTrap[$];
  logic [3:0]  qCause[$];
  logic [31:0] qVal[$];
  string       qReq[$];

  always #5 clk = ~clk;

  wfi_gate u0 (
    .clk(clk), .rst(rst), .instValid(instValid), .instIsWfi(instIsWfi),
    .instIsEcall(instIsEcall), .instPc(instPc), .privUser(privUser),
    .mstatusIn(mstatusIn), .execOk(execOk), .irqPending(irqPending),
    .irqEnable(irqEnable), .trapReq(trapReq), .trapCause(trapCause),
    .trapEpc(trapEpc), .retire(retire), .nextPc(nextPc), .stall(stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // kind: 0 = expect nothing, 1 = trap, 2 = retire
  task automatic issue(input logic wfi, input logic ecall, input logic user,
                       input logic [31:0] status, input logic xok, input logic [31:0] pc,
                       input int kind, input logic [3:0] cause, input logic [31:0] val,
                       input string req);
    @(negedge clk);
    instValid = 1'b1; instIsWfi = wfi; instIsEcall = ecall; privUser = user;
    mstatusIn = status; execOk = xok; instPc = pc;
    if (kind != 0) begin
      qTrap.push_back(kind == 1); qCause.push_back(cause);
      qVal.push_back(val); qReq.push_back(req);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    instValid = 1'b0; instIsWfi = 1'b0; instIsEcall = 1'b0;
  endtask

  // Monitor: every result pulse is compared with the head of the queue.
  always @(posedge clk) begin
    #2;
    if (!done && (trapReq || retire)) begin
      checks++;
      if (qTrap.size() == 0) begin
        fails++;
        $display("FAIL unexpected result: trap %0b cause %0d epc %h retire %0b next %h expected none",
                 trapReq, trapCause, trapEpc, retire, nextPc);
      end else begin
        automatic bit          eT = qTrap.pop_front();
        automatic logic [3:0]  eC = qCause.pop_front();
        automatic logic [31:0] eV = qVal.pop_front();
        automatic string       eR = qReq.pop_front();
        if (eT) begin
          if (!(trapReq && !retire && trapCause == eC && trapEpc == eV)) begin
            fails++;
            $display("FAIL %s: actual trap %0b cause %0d epc %h expected trap cause %0d epc %h",
                     eR, trapReq, trapCause, trapEpc, eC, eV);
          end
        end else if (!(retire && !trapReq && nextPc == eV)) begin
          fails++;
          $display("FAIL %s: actual retire %0b next %h expected retire next %h",
                   eR, retire, nextPc, eV);
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    rst = 1'b1; instValid = 0; instIsWfi = 0; instIsEcall = 0; privUser = 1;
    mstatusIn = 0; execOk = 1; instPc = 0; irqPending = 0; irqEnable = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset stall", 32'(stall), 0);
    chk("R11 reset trapReq", 32'(trapReq), 0);
    chk("R11 reset retire", 32'(retire), 0);
    rst = 1'b0;

    // R6: enabled pending interrupt, WFI does not block
    irqPending = 16'h0080; irqEnable = 16'h0080;
    issue(1, 0, 1, 0, 1, 32'h100, 2, 0, 32'h104, "R6 wfi passthrough");
    idle();
    chk("R6 no stall", 32'(stall), 0);

    // R1/R2: TW set, no interrupts enabled
    irqPending = 0; irqEnable = 0;
    issue(1, 0, 1, TW_ON, 1, 32'h200, 1, 4'd2, 32'h200, "R1 tw illegal");
    idle();
    chk("R2 no stall after tw trap", 32'(stall), 0);
    idle();
    chk("R2 still no stall", 32'(stall), 0);

    // R1: all other status bits have no effect
    irqPending = 16'h0001; irqEnable = 16'h0001;
    issue(1, 0, 1, ~TW_ON, 1, 32'h210, 2, 0, 32'h214, "R1 other bits ignored");
    idle();

    // R3/R4: execute fault
    irqPending = 0; irqEnable = 0;
    issue(1, 0, 1, 0, 0, 32'h300, 1, 4'd1, 32'h300, "R3 fetch fault wfi");
    idle();
    chk("R3 no stall after fault", 32'(stall), 0);
    issue(1, 0, 1, TW_ON, 0, 32'h310, 1, 4'd1, 32'h310, "R4 fault over tw");
    idle();
    chk("R4 no stall", 32'(stall), 0);

    // R5: machine mode ignores TW
    irqPending = 16'h0100; irqEnable = 16'h0100;
    issue(1, 0, 0, TW_ON, 1, 32'h400, 2, 0, 32'h404, "R5 machine wfi");
    idle();

    // R8: ecall causes
    issue(0, 1, 1, 0, 1, 32'h500, 1, 4'd8, 32'h500, "R8 user ecall");
    idle();
    issue(0, 1, 0, 0, 1, 32'h510, 1, 4'd11, 32'h510, "R8 machine ecall");
    idle();

    // R12: ordinary instruction
    issue(0, 0, 1, 0, 1, 32'h600, 2, 0, 32'h604, "R12 plain retire");
    idle();

    // R7/R10: sleep and wake-up
    irqPending = 0; irqEnable = 0;
    issue(1, 0, 1, 0, 1, 32'h700, 2, 0, 32'h704, "R7 wake retire");
    idle();
    chk("R7 stall while asleep", 32'(stall), 1);
    issue(0, 1, 0, 0, 1, 32'h708, 0, 0, 0, "R10 ignored");
    issue(0, 0, 1, 0, 0, 32'h70c, 0, 0, 0, "R10 ignored");
    idle();
    chk("R10 still asleep", 32'(stall), 1);
    irqPending = 16'h0008;
    #1;
    chk("R6 disabled pending does not wake", 32'(stall), 1);
    @(negedge clk);
    irqEnable = 16'h0008;
    #1;
    chk("R7 stall drops on wake", 32'(stall), 0);
    idle();
    irqPending = 0; irqEnable = 0;
    idle();

    // R9/R10: one-cycle trap; instruction during trap ignored
    issue(1, 0, 1, 0, 0, 32'h800, 1, 4'd1, 32'h800, "R9 trap");
    issue(0, 1, 1, 0, 1, 32'h810, 0, 0, 0, "R10 ignored");
    chk("R9 trap high", 32'(trapReq), 1);
    chk("R9 no stall with trap", 32'(stall), 0);
    idle();
    chk("R9 trap one cycle", 32'(trapReq), 0);
    idle();

    // R11: reset while asleep
    issue(1, 0, 1, 0, 1, 32'h900, 0, 0, 0, "R11");
    idle();
    chk("R11 asleep before reset", 32'(stall), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 stall cleared", 32'(stall), 0);
    irqPending = 16'h0002; irqEnable = 16'h0002;
    idle();
    idle();
    chk("R11 no retire after reset", 32'(retire), 0);

    repeat (3) idle();
    chk("all expected results seen", qTrap.size(), 0);
    done = 1'b1;
    summary();
  end

endmodule